// File: doc/BRIEF.md
# Register-Mapped NAND Flash Bridge

This block sits on a simple 32-bit memory-mapped bus as a slave with one register and drives an 8-bit NAND flash device. A host write carries an operation code in bits 30:28, a chip-enable request in bit 31 and a byte in bits 23:16. The bridge turns it into a command-latch, address-latch or data-write cycle on the flash pins. Each cycle is a single write-enable pulse with programmable setup, low and hold times counted in clock cycles.

A write with the read-arm operation puts the bridge in a streaming read mode. From then on, every host read of the register produces one read-enable pulse and returns the sampled flash byte, so back-to-back reads walk through the device's output stream. A 16-bit value is fetched as two such reads. Every read also reports the synchronized ready/busy pin. The bus handshake is a level request that the host holds until a one-cycle acknowledge. The acknowledge is withheld until any flash cycle started by the access has fully completed.

Top module: `nand_bridge`

## Requirements
- R1: A write whose bits 30:28 hold 0, 1 or 3 produces exactly one write-enable pulse, with the byte from bits 23:16 on the flash I/O lines and the I/O driver enabled. CLE is high only for code 0, ALE is high only for code 1, and neither is high for code 3.
- R2: Bit 31 of every accepted write sets the chip-enable: 1 drives the active-low chip-enable low and 0 drives it high. The new level is already in effect during that write's own strobe.
- R3: A write with code 2 arms read mode. Each later register read then gives one read-enable pulse with the I/O driver off and no write-enable pulse, and returns the sampled flash byte in bits 23:16. Consecutive reads return consecutive bytes of the stream, so a 16-bit value is the first read's byte followed by the second's.
- R4: Without read mode, a register read returns status only, with zero in bits 23:16, produces no read-enable pulse and is acknowledged one cycle after acceptance.
- R5: Read data bit 15 is 1 when the ready/busy input is low (busy) and 0 when it is high, seen through a two-flop synchronizer. Bits 31:24 and 14:0 of read data are always zero.
- R6: A strobe stays high for T_SETUP cycles after acceptance, is low for T_LOW cycles and is high for T_HOLD cycles. The acknowledge is a single-cycle pulse, due T_SETUP+T_LOW+T_HOLD+1 cycles after acceptance for a strobed access and 1 cycle after acceptance otherwise.
- R7: CLE and ALE are never high together, write-enable and read-enable are never low together, and the I/O driver is enabled whenever write-enable is low.
- R8: Synchronous reset drives chip-enable, write-enable and read-enable high, drives CLE, ALE and acknowledge low, and clears read mode.
- R9: A write with code 2 or with codes 4 to 7 produces no flash strobe and is acknowledged one cycle after acceptance. Any code other than 2 clears read mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Bus request, held until acknowledge |
| req_write | input | 1 | 1 for a register write, 0 for a read |
| req_wdata | input | 32 | Write data: bit 31 chip-enable, 30:28 code, 23:16 byte |
| req_ack | output | 1 | One-cycle acknowledge |
| rd_data | output | 32 | Read data: 23:16 byte, bit 15 busy, rest zero |
| nf_ce_n | output | 1 | Flash chip-enable, active low |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write-enable strobe, active low |
| nf_re_n | output | 1 | Read-enable strobe, active low |
| nf_io_out | output | 8 | Byte driven to flash I/O |
| nf_io_oe | output | 1 | Output enable for the I/O driver |
| nf_io_in | input | 8 | Byte read from flash I/O |
| nf_rb_n | input | 1 | Flash ready/busy, low while busy |

## Verification
The acknowledge of a strobed access is due T_SETUP+T_LOW+T_HOLD+1 cycles after acceptance, and that of an unstrobed one after a single cycle. The first low cycle of a strobe is due T_SETUP+1 cycles after the request is driven. A busy change reaches bit 15 only after two clock edges. The bench counts clock edges from the cycle it raises a request and compares each count with these figures computed from the parameters. It samples everything on the falling edge. A read launched in the same cycle as a ready/busy change is expected to return the old level, and a read two cycles later the new one.

// File: rtl/nb_pkg.sv
package nb_pkg;

  localparam int BUS_W = 32;

  localparam logic [2:0] OPC_CMD   = 3'd0;
  localparam logic [2:0] OPC_ADDR  = 3'd1;
  localparam logic [2:0] OPC_RDARM = 3'd2;
  localparam logic [2:0] OPC_WDATA = 3'd3;

  typedef enum logic [1:0] {ST_IDLE, ST_BUSY, ST_ACK} nb_state_e;

  function automatic logic [2:0] f_opcode(input logic [BUS_W-1:0] w);
    return w[30:28];
  endfunction

  function automatic logic [7:0] f_byte(input logic [BUS_W-1:0] w);
    return w[23:16];
  endfunction

  function automatic logic f_ce_req(input logic [BUS_W-1:0] w);
    return w[31];
  endfunction

  function automatic logic f_is_strobed_op(input logic [2:0] op);
    return (op == OPC_CMD) || (op == OPC_ADDR) || (op == OPC_WDATA);
  endfunction

  function automatic logic [BUS_W-1:0] f_status(input logic [7:0] b, input logic busy);
    return {8'h00, b, busy, 15'h0000};
  endfunction

  function automatic logic f_in_low(input int cnt, input int setup, input int low);
    return (cnt >= setup) && (cnt < setup + low);
  endfunction

endpackage

// File: rtl/nb_sync.sv
module nb_sync #(
  parameter int STAGES = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= RST_VAL;
    else     chain[0] <= d;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[g] <= RST_VAL;
      else     chain[g] <= chain[g-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/nb_strobe.sv
module nb_strobe #(
  parameter int T_SETUP = 1,
  parameter int T_LOW   = 2,
  parameter int T_HOLD  = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic active,
  output logic low,
  output logic sample,
  output logic done
);
  import nb_pkg::*;

  localparam int TOTAL = T_SETUP + T_LOW + T_HOLD;
  localparam int CW    = $clog2(TOTAL + 1);

  logic [CW-1:0] cnt;
  logic          act_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= 1'b0;
      cnt   <= '0;
    end else if (start && !act_q) begin
      act_q <= 1'b1;
      cnt   <= '0;
    end else if (act_q) begin
      if (int'(cnt) == TOTAL - 1) begin
        act_q <= 1'b0;
        cnt   <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign active = act_q;
  assign low    = act_q && f_in_low(int'(cnt), T_SETUP, T_LOW);
  assign sample = act_q && (int'(cnt) == T_SETUP + T_LOW - 1);
  assign done   = act_q && (int'(cnt) == TOTAL - 1);

  // R6: the strobe is low only inside an active window, and a window ends before restart
  assert_low_in_window_R6: assert property (@(posedge clk) disable iff (rst)
    low |-> active);
  assert_done_ends_window_R6: assert property (@(posedge clk) disable iff (rst)
    done |=> !active);
endmodule

// File: rtl/nand_bridge.sv
module nand_bridge #(
  parameter int T_SETUP = 1,
  parameter int T_LOW   = 2,
  parameter int T_HOLD  = 1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [31:0] req_wdata,
  output logic        req_ack,
  output logic [31:0] rd_data,
  output logic        nf_ce_n,
  output logic        nf_cle,
  output logic        nf_ale,
  output logic        nf_we_n,
  output logic        nf_re_n,
  output logic [7:0]  nf_io_out,
  output logic        nf_io_oe,
  input  logic [7:0]  nf_io_in,
  input  logic        nf_rb_n
);
  import nb_pkg::*;

  nb_state_e   state;
  logic        ce_q, cle_q, ale_q, wr_q, rd_mode_q;
  logic [7:0]  io_q, byte_q;
  logic [31:0] rdata_q;

  logic rb_sync, busy;
  logic stb_active, stb_low, stb_sample, stb_done;
  logic accept, go_write, go_read, stb_start;
  logic [2:0] op;
  logic [7:0] rd_byte_n;

  nb_sync #(.STAGES(2), .RST_VAL(1'b1)) i_sync (
    .clk(clk), .rst(rst), .d(nf_rb_n), .q(rb_sync)
  );

  nb_strobe #(.T_SETUP(T_SETUP), .T_LOW(T_LOW), .T_HOLD(T_HOLD)) i_strobe (
    .clk(clk), .rst(rst), .start(stb_start),
    .active(stb_active), .low(stb_low), .sample(stb_sample), .done(stb_done)
  );

  assign busy      = ~rb_sync;
  assign op        = f_opcode(req_wdata);
  assign accept    = (state == ST_IDLE) && req_valid;
  assign go_write  = accept && req_write && f_is_strobed_op(op);
  assign go_read   = accept && !req_write && rd_mode_q;
  assign stb_start = (go_write || go_read) && !stb_active;
  assign rd_byte_n = stb_sample ? nf_io_in : byte_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      ce_q      <= 1'b0;
      cle_q     <= 1'b0;
      ale_q     <= 1'b0;
      wr_q      <= 1'b0;
      rd_mode_q <= 1'b0;
      io_q      <= 8'h00;
      byte_q    <= 8'h00;
      rdata_q   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (accept && req_write) begin
            ce_q      <= f_ce_req(req_wdata);
            rd_mode_q <= (op == OPC_RDARM);
            rdata_q   <= f_status(8'h00, busy);
            if (go_write) begin
              cle_q <= (op == OPC_CMD);
              ale_q <= (op == OPC_ADDR);
              wr_q  <= 1'b1;
              io_q  <= f_byte(req_wdata);
              state <= ST_BUSY;
            end else begin
              state <= ST_ACK;
            end
          end else if (accept) begin
            if (go_read) begin
              wr_q  <= 1'b0;
              state <= ST_BUSY;
            end else begin
              rdata_q <= f_status(8'h00, busy);
              state   <= ST_ACK;
            end
          end
        end
        ST_BUSY: begin
          if (stb_sample && !wr_q) byte_q <= nf_io_in;
          if (stb_done) begin
            cle_q   <= 1'b0;
            ale_q   <= 1'b0;
            wr_q    <= 1'b0;
            rdata_q <= f_status(wr_q ? 8'h00 : rd_byte_n, busy);
            state   <= ST_ACK;
          end
        end
        ST_ACK:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ack   = (state == ST_ACK);
  assign rd_data   = rdata_q;
  assign nf_ce_n   = ~ce_q;
  assign nf_cle    = cle_q;
  assign nf_ale    = ale_q;
  assign nf_we_n   = ~(stb_low && wr_q);
  assign nf_re_n   = ~(stb_low && !wr_q);
  assign nf_io_out = io_q;
  assign nf_io_oe  = wr_q;

  // R7: latch enables and strobes are mutually exclusive, driver on during writes
  assert_cle_ale_excl_R7: assert property (@(posedge clk) disable iff (rst)
    !(nf_cle && nf_ale));
  assert_we_re_excl_R7: assert property (@(posedge clk) disable iff (rst)
    nf_we_n || nf_re_n);
  assert_oe_with_we_R7: assert property (@(posedge clk) disable iff (rst)
    !nf_we_n |-> nf_io_oe);
  // R1: the byte on the I/O lines does not move while write-enable is low
  assert_io_stable_R1: assert property (@(posedge clk) disable iff (rst)
    (!nf_we_n && $past(!nf_we_n)) |-> $stable(nf_io_out));
  // R3: a read strobe never drives the I/O lines
  assert_re_no_drive_R3: assert property (@(posedge clk) disable iff (rst)
    !nf_re_n |-> !nf_io_oe);
  // R6: the acknowledge lasts exactly one cycle and never overlaps a strobe
  assert_ack_single_R6: assert property (@(posedge clk) disable iff (rst)
    req_ack |=> !req_ack);
  assert_ack_after_strobe_R6: assert property (@(posedge clk) disable iff (rst)
    req_ack |-> (nf_we_n && nf_re_n));
endmodule

// File: tb/test_nand_bridge.sv
module test_nand_bridge;
  localparam int SU = 1, LO = 2, HO = 1;
  localparam int STB_LAT = SU + LO + HO + 1;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_wdata = '0;
  logic req_ack;
  logic [31:0] rd_data;
  logic nf_ce_n, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_io_oe;
  logic [7:0] nf_io_out, nf_io_in;
  logic nf_rb_n = 1'b1;

  int checks = 0, fails = 0;
  int cyc = 0;
  int we_cnt = 0, re_cnt = 0, we_lo = 0, re_lo = 0, we_len = 0, re_len = 0;
  int we_fall_at = 0, re_fall_at = 0;
  logic cap_cle, cap_ale, cap_ce_n, cap_oe, cap_re_oe;
  logic [7:0] cap_io;
  logic [7:0] stream_base = 8'h5A;
  int t_req = 0, lat = 0;
  logic [31:0] rdv;

  always #4 clk = ~clk;

  nand_bridge #(.T_SETUP(SU), .T_LOW(LO), .T_HOLD(HO)) i_nand_bridge (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_wdata(req_wdata), .req_ack(req_ack), .rd_data(rd_data),
    .nf_ce_n(nf_ce_n), .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_we_n(nf_we_n),
    .nf_re_n(nf_re_n), .nf_io_out(nf_io_out), .nf_io_oe(nf_io_oe),
    .nf_io_in(nf_io_in), .nf_rb_n(nf_rb_n)
  );

  // flash model: stream of bytes advancing on each read pulse
  assign nf_io_in = stream_base + 8'(re_cnt);

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!nf_we_n) begin
      if (we_lo == 0) we_fall_at = cyc;
      we_lo++;
      cap_cle = nf_cle; cap_ale = nf_ale; cap_io = nf_io_out;
      cap_ce_n = nf_ce_n; cap_oe = nf_io_oe;
    end else if (we_lo != 0) begin
      we_cnt++; we_len = we_lo; we_lo = 0;
    end
    if (!nf_re_n) begin
      if (re_lo == 0) re_fall_at = cyc;
      re_lo++;
      cap_re_oe = nf_io_oe;
    end else if (re_lo != 0) begin
      re_cnt++; re_len = re_lo; re_lo = 0;
    end
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic bus(input logic wr, input logic [31:0] wd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_wdata = wd; t_req = cyc;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!req_ack && lat < 60);
    rdv = rd_data;
    req_valid = 1'b0;
    if (!req_ack) chk("R6", "ack timeout", 0, 1);
  endtask

  function automatic logic [31:0] wword(input logic ce, input logic [2:0] op, input logic [7:0] b);
    return {ce, op, 4'h0, b, 16'h0000};
  endfunction

  function automatic logic [31:0] sword(input logic [7:0] b, input logic bz);
    return (32'(b) << 16) | (32'(bz) << 15);
  endfunction

  initial begin
    int guard = 0;
    while (guard < 200000) begin
      @(posedge clk);
      guard++;
    end
    chk("WD", "watchdog expired", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int w0, r0;
    repeat (4) @(negedge clk);
    // R8: reset state
    chk("R8", "ce_n", nf_ce_n, 1); chk("R8", "we_n", nf_we_n, 1);
    chk("R8", "re_n", nf_re_n, 1); chk("R8", "cle", nf_cle, 0);
    chk("R8", "ale", nf_ale, 0);   chk("R8", "ack", req_ack, 0);
    rst = 1'b0;

    // R5: two-flop synchronizer delay on busy reporting
    @(negedge clk);
    nf_rb_n = 1'b0;
    bus(1'b0, 32'h0);
    chk("R5", "busy seen too early", rdv, sword(8'h00, 1'b0));
    repeat (3) @(negedge clk);
    bus(1'b0, 32'h0);
    chk("R5", "busy bit", rdv, sword(8'h00, 1'b1));
    nf_rb_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1/R2/R6: exhaustive byte sweep over the three strobed codes
    for (int o = 0; o < 3; o++) begin
      logic [2:0] opc;
      opc = (o == 2) ? 3'd3 : 3'(o);
      for (int b = 0; b < 256; b++) begin
        w0 = we_cnt;
        bus(1'b1, wword(1'b1, opc, 8'(b)));
        chk("R6", "write ack latency", lat, STB_LAT);
        chk("R1", "one we pulse", we_cnt - w0, 1);
        chk("R1", "io byte", cap_io, b);
        chk("R1", "cle", cap_cle, opc == 3'd0);
        chk("R1", "ale", cap_ale, opc == 3'd1);
        chk("R7", "driver on", cap_oe, 1);
        chk("R2", "ce_n during strobe", cap_ce_n, 0);
        chk("R6", "we low length", we_len, LO);
        chk("R6", "we setup", we_fall_at - t_req, SU + 1);
      end
    end

    // R2: chip-enable request clear, applied in its own strobe
    bus(1'b1, wword(1'b0, 3'd3, 8'hC3));
    chk("R2", "ce_n during ce=0 strobe", cap_ce_n, 1);
    chk("R2", "ce_n after", nf_ce_n, 1);

    // R4: read without read mode
    r0 = re_cnt;
    bus(1'b0, 32'h0);
    chk("R4", "status read latency", lat, 1);
    chk("R4", "status data", rdv, sword(8'h00, 1'b0));
    chk("R4", "no re pulse", re_cnt - r0, 0);

    // R3: arm and stream reads, including a 16-bit pair
    bus(1'b1, wword(1'b1, 3'd2, 8'h00));
    chk("R9", "arm latency", lat, 1);
    chk("R2", "ce_n after arm", nf_ce_n, 0);
    for (int k = 0; k < 8; k++) begin
      logic [7:0] expb;
      expb = stream_base + 8'(re_cnt);
      r0 = re_cnt; w0 = we_cnt;
      bus(1'b0, 32'h0);
      chk("R3", "read byte", rdv, sword(expb, 1'b0));
      chk("R3", "one re pulse", re_cnt - r0, 1);
      chk("R3", "no we pulse", we_cnt - w0, 0);
      chk("R3", "driver off", cap_re_oe, 0);
      chk("R6", "read latency", lat, STB_LAT);
      chk("R6", "re low length", re_len, LO);
      chk("R6", "re setup", re_fall_at - t_req, SU + 1);
    end

    // R5: busy reported alongside read data
    nf_rb_n = 1'b0;
    repeat (3) @(negedge clk);
    begin
      logic [7:0] expb;
      expb = stream_base + 8'(re_cnt);
      bus(1'b0, 32'h0);
      chk("R5", "data with busy", rdv, sword(expb, 1'b1));
    end
    nf_rb_n = 1'b1;
    repeat (3) @(negedge clk);

    // R9: codes 4..7 strobe nothing and clear read mode
    for (int c = 4; c < 8; c++) begin
      bus(1'b1, wword(1'b1, 3'd2, 8'h00));
      w0 = we_cnt; r0 = re_cnt;
      bus(1'b1, wword(c[0], 3'(c), 8'hA5));
      chk("R9", "no strobe latency", lat, 1);
      chk("R9", "no we pulse", we_cnt - w0, 0);
      chk("R2", "ce follows bit31", nf_ce_n, !c[0]);
      bus(1'b0, 32'h0);
      chk("R4", "read mode cleared", re_cnt - r0, 0);
      chk("R4", "status only", rdv, sword(8'h00, 1'b0));
    end

    // R8: reset clears read mode
    bus(1'b1, wword(1'b1, 3'd2, 8'h00));
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R8", "ce_n after reset", nf_ce_n, 1);
    rst = 1'b0;
    r0 = re_cnt;
    bus(1'b0, 32'h0);
    chk("R8", "read mode cleared by reset", re_cnt - r0, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule